// File: doc/BRIEF.md
# Two-Output Grouped Interrupt Controller

This block collects a wide vector of interrupt sources, organised as groups of 32, and presents them to a parent controller on two interrupt lines. Software configures each source through four per-source bit arrays: trigger kind, active sense, destination output and enable. Edge sources are latched until software clears them. Level sources follow the input after the sense correction.

For each output the block exposes one masked pending word per group. A packed summary word shows which groups hold anything pending for either output. A handler reads the summary, picks a group, then reads that group's masked word to find the source. Inputs pass through a configurable flip-flop synchroniser before any detection. All register access uses one 32-bit port with a window select and a byte address. Reads are combinational and writes take effect on the clock edge.

Top module: `grp_irq_ctrl`

## Requirements
- R1: After reset every configuration bit is 0, both interrupt outputs are low, and every readable word returns 0.
- R2: In window 0 (reg_win=0), group g's trigger word is at byte 4g, its sense word at 28+4g, its destination word at 56+4g and its enable word at 84+4g. Each reads back exactly what was written, with bit b standing for source 32g+b.
- R3: A level source (trigger bit 0) with sense bit 0 is pending exactly while its input is high, two clock edges after the input changes.
- R4: A level source with sense bit 1 is pending exactly while its input is low.
- R5: An edge source (trigger bit 1) with sense bit 0 latches pending on a rising input edge, even a one-cycle pulse, and stays pending after the input falls until cleared.
- R6: An edge source with sense bit 1 latches only on a falling edge; a rising edge leaves it idle.
- R7: In window 1, writing 1 to bit b of the clear word at byte 4g clears the latch of source 32g+b, and writing 0 leaves it pending.
- R8: A source whose enable bit is 0 appears in no masked word and drives neither output.
- R9: A destination bit of 1 routes the source to output 0, whose masked word for group g is at window 1 byte 56+4g. A bit of 0 routes it to output 1, whose masked word is at byte 28+4g.
- R10: The summary word at window 1 byte 124 sets bit g for a group with a masked pending source on output 1, and bit 8+g for output 0. All other bits read 0.
- R11: When an edge event and a clear write hit the same source in the same cycle, the source stays pending.
- R12: Each interrupt output is high exactly when some masked pending bit for it is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_win | input | 1 | Register window select: 0 configuration, 1 clear/status |
| reg_addr | input | 7 | Byte address inside the window (bits 1:0 ignored) |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| src_raw | input | 224 | Raw interrupt source inputs |
| irq_out0 | output | 1 | Interrupt line 0 to the parent |
| irq_out1 | output | 1 | Interrupt line 1 to the parent |

## Verification
The bench builds the block with its default parameters: 224 sources in seven groups and a two-flop synchroniser. With these values it reaches the last, 7th group (source 223), the summary bits at both offsets, and both destinations. Because the synchroniser depth is fixed at two, the bench can predict exact cycles. It checks level pending two edges after an input change, and edge latching one edge later. It also lines up an edge event and a clear write on the same clock edge.

// File: rtl/grp_irq_pkg.sv
package grp_irq_pkg;
   typedef enum logic [1:0] {
      CFG_TRIG = 2'd0,
      CFG_SENSE = 2'd1,
      CFG_DEST = 2'd2,
      CFG_EN = 2'd3
   } cfg_arr_e;

   localparam int CFG_ARRAYS = 4;
   localparam int REG_DW = 32;

   function automatic int ceil_div(input int a, input int b);
      return (a + b - 1) / b;
   endfunction
endpackage

// File: rtl/irq_src_sync.sv
module irq_src_sync #(
   parameter int W = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] raw,
   output logic [W-1:0] synced,
   output logic [W-1:0] synced_prev
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("irq_src_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] chain [STAGES+1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i <= STAGES; i++) chain[i] <= '0;
      end else begin
         chain[0] <= raw;
         for (int i = 1; i <= STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign synced      = chain[STAGES-1];
   assign synced_prev = chain[STAGES];
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
   import grp_irq_pkg::*;
#(
   parameter int NUM_SRC = 224,
   parameter int GRP_W = 32,
   localparam int NUM_GRP = ceil_div(NUM_SRC, GRP_W),
   localparam int TOT = NUM_GRP * GRP_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [4:0]       widx,
   input  logic [GRP_W-1:0] wdata,
   output logic [GRP_W-1:0] rdata,
   output logic [TOT-1:0]   trig,
   output logic [TOT-1:0]   sense,
   output logic [TOT-1:0]   dest,
   output logic [TOT-1:0]   en
);
   logic [GRP_W-1:0] cfg [CFG_ARRAYS][NUM_GRP];
   logic [TOT-1:0]   valid;

   genvar a, g, b;
   generate
      for (b = 0; b < TOT; b++) begin : g_valid
         assign valid[b] = (b < NUM_SRC);
      end
      for (a = 0; a < CFG_ARRAYS; a++) begin : g_arr
         for (g = 0; g < NUM_GRP; g++) begin : g_grp
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) cfg[a][g] <= '0;
               else if (wr_en && (int'(widx) == a * NUM_GRP + g))
                  cfg[a][g] <= wdata & valid[g*GRP_W +: GRP_W];
            end
         end
      end
      for (g = 0; g < NUM_GRP; g++) begin : g_out
         assign trig[g*GRP_W +: GRP_W]  = cfg[CFG_TRIG][g];
         assign sense[g*GRP_W +: GRP_W] = cfg[CFG_SENSE][g];
         assign dest[g*GRP_W +: GRP_W]  = cfg[CFG_DEST][g];
         assign en[g*GRP_W +: GRP_W]    = cfg[CFG_EN][g];
      end
   endgenerate

   always_comb begin
      rdata = '0;
      for (int ai = 0; ai < CFG_ARRAYS; ai++)
         for (int gi = 0; gi < NUM_GRP; gi++)
            if (int'(widx) == ai * NUM_GRP + gi) rdata = cfg[ai][gi];
   end
endmodule

// File: rtl/irq_pend_core.sv
module irq_pend_core #(
   parameter int TOT = 224
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [TOT-1:0] synced,
   input  logic [TOT-1:0] synced_prev,
   input  logic [TOT-1:0] trig,
   input  logic [TOT-1:0] sense,
   input  logic [TOT-1:0] dest,
   input  logic [TOT-1:0] en,
   input  logic [TOT-1:0] clr,
   output logic [TOT-1:0] edge_evt,
   output logic [TOT-1:0] edge_latch,
   output logic [TOT-1:0] mpend0,
   output logic [TOT-1:0] mpend1
);
   logic [TOT-1:0] rise, fall, pend;

   assign rise     = synced & ~synced_prev;
   assign fall     = ~synced & synced_prev;
   assign edge_evt = trig & ((~sense & rise) | (sense & fall));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) edge_latch <= '0;
      else        edge_latch <= trig & ((edge_latch & ~clr) | edge_evt);
   end

   assign pend   = (trig & edge_latch) | (~trig & (synced ^ sense));
   assign mpend0 = pend & en & dest;
   assign mpend1 = pend & en & ~dest;
endmodule

// File: rtl/irq_group_sum.sv
module irq_group_sum #(
   parameter int NUM_GRP = 7,
   parameter int GRP_W = 32,
   localparam int TOT = NUM_GRP * GRP_W
) (
   input  logic [TOT-1:0]     mpend,
   output logic [NUM_GRP-1:0] flags
);
   genvar g;
   generate
      for (g = 0; g < NUM_GRP; g++) begin : g_or
         assign flags[g] = |mpend[g*GRP_W +: GRP_W];
      end
   endgenerate
endmodule

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl
   import grp_irq_pkg::*;
#(
   parameter int NUM_SRC = 224,
   parameter int GRP_W = 32,
   parameter int SYNC_STAGES = 2,
   parameter int SUM1_LSB = 0,
   parameter int SUM0_LSB = 8,
   parameter int SUM_WORD = 31,
   localparam int NUM_GRP = ceil_div(NUM_SRC, GRP_W),
   localparam int TOT = NUM_GRP * GRP_W,
   localparam int PEND1_BASE = NUM_GRP,
   localparam int PEND0_BASE = 2 * NUM_GRP
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_win,
   input  logic [6:0]         reg_addr,
   input  logic               reg_we,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   input  logic [NUM_SRC-1:0] src_raw,
   output logic               irq_out0,
   output logic               irq_out1
);
   generate
      if (GRP_W != REG_DW) begin : g_bad_grp
         $error("grp_irq_ctrl: GRP_W must equal the register width");
      end
      if (CFG_ARRAYS * NUM_GRP > 32) begin : g_bad_win0
         $error("grp_irq_ctrl: configuration arrays overflow window 0");
      end
      if (3 * NUM_GRP > SUM_WORD || SUM_WORD > 31) begin : g_bad_win1
         $error("grp_irq_ctrl: pending arrays collide with summary word");
      end
      if (SUM0_LSB < SUM1_LSB + NUM_GRP || SUM0_LSB + NUM_GRP > 32) begin : g_bad_sum
         $error("grp_irq_ctrl: summary fields overlap or overflow");
      end
   endgenerate

   logic [4:0]         widx;
   logic [TOT-1:0]     raw_pad, synced, synced_prev;
   logic [TOT-1:0]     cfg_trig, cfg_sense, cfg_dest, cfg_en;
   logic [TOT-1:0]     clr_vec, edge_evt, edge_latch, mpend0, mpend1;
   logic [NUM_GRP-1:0] grp_flags0, grp_flags1;
   logic [31:0]        rd_cfg, rd_stat, sum_word;

   assign widx    = reg_addr[6:2];
   assign raw_pad = TOT'(src_raw);

   irq_src_sync #(.W(TOT), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .raw(raw_pad),
      .synced(synced), .synced_prev(synced_prev)
   );

   irq_cfg_regs #(.NUM_SRC(NUM_SRC), .GRP_W(GRP_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_we & ~reg_win), .widx(widx),
      .wdata(reg_wdata), .rdata(rd_cfg), .trig(cfg_trig), .sense(cfg_sense),
      .dest(cfg_dest), .en(cfg_en)
   );

   genvar g;
   generate
      for (g = 0; g < NUM_GRP; g++) begin : g_clr
         assign clr_vec[g*GRP_W +: GRP_W] =
            (reg_we && reg_win && int'(widx) == g) ? reg_wdata : '0;
      end
   endgenerate

   irq_pend_core #(.TOT(TOT)) u_core (
      .clk(clk), .rst_n(rst_n), .synced(synced), .synced_prev(synced_prev),
      .trig(cfg_trig), .sense(cfg_sense), .dest(cfg_dest), .en(cfg_en),
      .clr(clr_vec), .edge_evt(edge_evt), .edge_latch(edge_latch),
      .mpend0(mpend0), .mpend1(mpend1)
   );

   irq_group_sum #(.NUM_GRP(NUM_GRP), .GRP_W(GRP_W)) u_sum0 (
      .mpend(mpend0), .flags(grp_flags0)
   );
   irq_group_sum #(.NUM_GRP(NUM_GRP), .GRP_W(GRP_W)) u_sum1 (
      .mpend(mpend1), .flags(grp_flags1)
   );

   assign sum_word = (32'(grp_flags1) << SUM1_LSB) | (32'(grp_flags0) << SUM0_LSB);

   always_comb begin
      rd_stat = '0;
      for (int gi = 0; gi < NUM_GRP; gi++) begin
         if (int'(widx) == PEND1_BASE + gi) rd_stat = mpend1[gi*GRP_W +: GRP_W];
         if (int'(widx) == PEND0_BASE + gi) rd_stat = mpend0[gi*GRP_W +: GRP_W];
      end
      if (int'(widx) == SUM_WORD) rd_stat = sum_word;
   end

   assign reg_rdata = reg_win ? rd_stat : rd_cfg;
   assign irq_out0  = |mpend0;
   assign irq_out1  = |mpend1;
endmodule

// File: rtl/grp_irq_chk.sv
module grp_irq_chk #(
   parameter int TOT = 224,
   parameter int NUM_GRP = 7
) (
   input logic               clk,
   input logic               rst_n,
   input logic               reg_win,
   input logic [6:0]         reg_addr,
   input logic [31:0]        reg_rdata,
   input logic               irq_out0,
   input logic               irq_out1,
   input logic [TOT-1:0]     trig,
   input logic [TOT-1:0]     clr,
   input logic [TOT-1:0]     evt,
   input logic [TOT-1:0]     latch,
   input logic [TOT-1:0]     en,
   input logic [TOT-1:0]     mpend0,
   input logic [TOT-1:0]     mpend1,
   input logic [NUM_GRP-1:0] flags0,
   input logic [NUM_GRP-1:0] flags1
);
   AST_EDGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(latch) & ~$past(clr) & $past(trig)) & trig & ~latch) == '0)); // R5
   AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(evt) & trig & ~latch) == '0)); // R11
   AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      ((mpend0 | mpend1) & ~en) == '0); // R8
   AST_ROUTE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (mpend0 & mpend1) == '0); // R9
   AST_OUT0_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out0 == (|flags0)); // R12
   AST_OUT1_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out1 == (|flags1)); // R12
   AST_SUM_SPARE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_win && reg_addr[6:2] == 5'd31) |-> (reg_rdata[31:15] == '0 && !reg_rdata[7])); // R10
endmodule

bind grp_irq_ctrl grp_irq_chk #(.TOT(TOT), .NUM_GRP(NUM_GRP)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_win(reg_win), .reg_addr(reg_addr),
   .reg_rdata(reg_rdata), .irq_out0(irq_out0), .irq_out1(irq_out1),
   .trig(cfg_trig), .clr(clr_vec), .evt(edge_evt), .latch(edge_latch),
   .en(cfg_en), .mpend0(mpend0), .mpend1(mpend1),
   .flags0(grp_flags0), .flags1(grp_flags1)
);

// File: tb/sim_grp_irq_ctrl.sv
module sim_grp_irq_ctrl;
   localparam int NS = 224;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_win = 1'b0;
   logic [6:0]    reg_addr = '0;
   logic          reg_we = 1'b0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic [NS-1:0] src_raw = '0;
   logic          irq_out0, irq_out1;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   grp_irq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .reg_win(reg_win), .reg_addr(reg_addr),
      .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .src_raw(src_raw), .irq_out0(irq_out0), .irq_out1(irq_out1)
   );

   // fields: idx[13:6] sense[5] dest[4] en[3] level[2] exp_out0[1] exp_out1[0]
   localparam int NV = 6;
   localparam logic [13:0] VEC [NV] = '{
      {8'd5,   1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},  // R3 R9 R12
      {8'd40,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},  // R3 R9 R12
      {8'd70,  1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},  // R4
      {8'd70,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},  // R4
      {8'd223, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},  // R8
      {8'd100, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}   // R3
   };

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic win, input int addr, input logic [31:0] data);
      @(negedge clk);
      reg_win = win; reg_addr = 7'(addr); reg_wdata = data; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic win, input int addr, output logic [31:0] data);
      @(negedge clk);
      reg_win = win; reg_addr = 7'(addr);
      #1 data = reg_rdata;
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      check({31'd0, irq_out0}, 0, "R1 irq_out0");
      check({31'd0, irq_out1}, 0, "R1 irq_out1");
      rd(0, 12, d);  check(d, 0, "R1 trig word");
      rd(0, 108, d); check(d, 0, "R1 enable word");
      rd(1, 124, d); check(d, 0, "R1 summary");

      // R2: layout and readback
      wr(0, 12, 32'hA5A5_0001);  rd(0, 12, d);  check(d, 32'hA5A5_0001, "R2 trig g3");
      wr(0, 52, 32'h1234_5678);  rd(0, 52, d);  check(d, 32'h1234_5678, "R2 sense g6");
      wr(0, 56, 32'hCAFE_0000);  rd(0, 56, d);  check(d, 32'hCAFE_0000, "R2 dest g0");
      wr(0, 108, 32'h0F0F_F0F0); rd(0, 108, d); check(d, 32'h0F0F_F0F0, "R2 en g6");
      rd(0, 8, d); check(d, 0, "R2 neighbour word untouched");
      wr(0, 12, 0); wr(0, 52, 0); wr(0, 56, 0); wr(0, 108, 0);

      // Level table: R3 R4 R8 R9 R12
      for (int v = 0; v < NV; v++) begin
         int idx, grp, bitn;
         logic [31:0] bm;
         idx = int'(VEC[v][13:6]); grp = idx / 32; bitn = idx % 32;
         bm = 32'd1 << bitn;
         wr(0, 28 + 4*grp, VEC[v][5] ? bm : 32'd0);
         wr(0, 56 + 4*grp, VEC[v][4] ? bm : 32'd0);
         wr(0, 84 + 4*grp, VEC[v][3] ? bm : 32'd0);
         src_raw[idx] = VEC[v][2];
         tick(3);
         check({31'd0, irq_out0}, {31'd0, VEC[v][1]}, "R12 R3 R4 table out0");
         check({31'd0, irq_out1}, {31'd0, VEC[v][0]}, "R12 R9 table out1");
         rd(1, (VEC[v][4] ? 56 : 28) + 4*grp, d);
         check(d, (VEC[v][1] | VEC[v][0]) ? bm : 32'd0, "R9 R8 table masked word");
         wr(0, 28 + 4*grp, 0); wr(0, 56 + 4*grp, 0); wr(0, 84 + 4*grp, 0);
         src_raw = '0;
         tick(3);
      end

      // R5: rising-edge pulse latched on source 33 (group 1, bit 1), to output 0
      wr(0, 4, 32'h2); wr(0, 60, 32'h2); wr(0, 88, 32'h2);
      @(negedge clk); src_raw[33] = 1'b1;
      @(negedge clk); src_raw[33] = 1'b0;
      tick(4);
      check({31'd0, irq_out0}, 1, "R5 latched after pulse");
      rd(1, 60, d);  check(d, 32'h2, "R5 R9 out0 masked word");
      rd(1, 124, d); check(d, 32'h200, "R10 summary out0 group1");
      // R7: writing 0 keeps it, writing 1 clears
      wr(1, 4, 32'h0); rd(1, 60, d); check(d, 32'h2, "R7 zero write no effect");
      wr(1, 4, 32'h2); rd(1, 60, d); check(d, 32'h0, "R7 clear");
      check({31'd0, irq_out0}, 0, "R7 output drops");

      // R6: falling edge only
      wr(0, 32, 32'h2);
      tick(2);
      check({31'd0, irq_out0}, 0, "R6 no spurious on sense change");
      src_raw[33] = 1'b1; tick(4);
      check({31'd0, irq_out0}, 0, "R6 rising ignored");
      src_raw[33] = 1'b0; tick(4);
      check({31'd0, irq_out0}, 1, "R6 falling latched");
      wr(1, 4, 32'h2); wr(0, 32, 0); wr(0, 4, 0); wr(0, 60, 0); wr(0, 88, 0);
      tick(2);

      // R11: event and clear in the same cycle, source 200 (group 6, bit 8) to output 1
      wr(0, 24, 32'h100); wr(0, 108, 32'h100);
      @(negedge clk); src_raw[200] = 1'b1;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      reg_win = 1'b1; reg_addr = 7'd24; reg_wdata = 32'h100; reg_we = 1'b1;
      @(negedge clk); reg_we = 1'b0;
      tick(1);
      check({31'd0, irq_out1}, 1, "R11 event wins over clear");
      rd(1, 52, d);  check(d, 32'h100, "R11 out1 masked word g6");
      rd(1, 124, d); check(d, 32'h40, "R10 summary out1 group6");
      wr(1, 24, 32'h100);
      check({31'd0, irq_out1}, 0, "R7 clear after R11");

      finish_run();
   end
endmodule